// File: doc/BRIEF.md
# Reference Divider with Coarse Phase/Frequency Detector

This block sits at the front of a synthesiser loop. It divides the oscillator clock by a programmable ratio R and then by a fixed factor of two, which gives a one-cycle comparison pulse at the oscillator frequency divided by 2·R. For example, a 10 MHz oscillator with R = 400 gives 12.5 kHz. A conventional up/down phase/frequency detector compares this pulse with a divided VCO pulse. Both pulses are single-cycle strobes in the oscillator clock domain. The detector measures the phase error in whole oscillator cycles.

The coarse correction output has three states. It is modelled as a drive enable plus a level: level 1 pumps the VCO up and level 0 pumps it down. The output drives only while a comparison is in progress and the loop is out of lock. When a finished comparison shows an error no larger than the programmed window, the coarse output is released and, at the same moment, the open-drain lock indicator pulls low. A separate fine detector then holds the loop. A comparison outside the window drops lock again.

Top module: `refdiv_pfd`

## Requirements
- R1: `ref_out` is a one-cycle pulse, and consecutive pulses are exactly 2·Reff oscillator cycles apart, where Reff is the programmed ratio after clamping.
- R2: An `r_val` below 3 behaves exactly as 3 (period 6). The largest value, 2047, gives a period of 4094.
- R3: A new `r_val` is loaded only at the divider's terminal count, so no cycle is truncated. Across a change from ratio o to ratio n, every pulse interval is 2o, o+n or 2n, and the intervals settle at 2n.
- R4: When the reference pulse leads the VCO pulse by d ≥ 1 cycles and the loop is unlocked, `pd_drive` is 1 with `pd_level` = 1 for the d cycles that follow the reference pulse, and 0 afterwards.
- R5: When the VCO pulse leads the reference pulse by d ≥ 1 cycles and the loop is unlocked, `pd_drive` is 1 with `pd_level` = 0 for the d cycles that follow the VCO pulse.
- R6: The up and down states are never active together. Reference and VCO pulses in the same cycle finish a comparison with error 0 and produce no drive.
- R7: The phase error is the number of oscillator cycles between the two pulses. Two cycles after the later pulse, `lock_pull` becomes 1 if the error is ≤ `win_cycles` and 0 otherwise.
- R8: While `lock_pull` is 1, `pd_drive` stays 0.
- R9: Reset (synchronous, active high) clears `ref_out`, `pd_drive` and `lock_pull`, so the block starts unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| r_val | input | 11 | Programmed reference ratio R |
| win_cycles | input | 12 | Lock window, in oscillator cycles |
| vco_pulse | input | 1 | Divided VCO strobe, one cycle wide |
| ref_out | output | 1 | Comparison-frequency strobe |
| pd_drive | output | 1 | Coarse output enable (0 = high impedance) |
| pd_level | output | 1 | Coarse output level, 1 = up, 0 = down |
| lock_pull | output | 1 | Open-drain lock indicator: 1 pulls the pin low (locked) |

## Verification
The assertions check on every cycle the properties that hold at all times:
- up and down are never active together;
- the coarse output drives only while one of the detector states is set, and never while locked;
- the level does not change during a drive stretch;
- reference pulses never come back to back;
- the active ratio never falls below 3;
- lock changes only in the cycle after a finished comparison.

Only the bench scenarios can show the numbers. These are the exact pulse spacing for many ratios, including the clamp and the maximum; the interval sets across a ratio change; the length and direction of each drive stretch for lead and lag offsets; and the lock decision at the window boundary.

// File: rtl/refpfd_pkg.sv
package refpfd_pkg;

    // Widths and limits of the datapath
    parameter int REF_R_W  = 11;
    parameter int PERR_W   = 12;
    parameter int R_MIN    = 3;

    typedef logic [REF_R_W-1:0] rval_t;
    typedef logic [PERR_W-1:0]  perr_t;

    // State of the two detector flip-flops
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

    // Result of one finished comparison
    typedef struct packed {
        logic  valid;
        perr_t err;
    } cmp_result_t;

    // Ratios below the minimum run at the minimum
    function automatic rval_t clamp_ratio(rval_t r);
        return (r < rval_t'(R_MIN)) ? rval_t'(R_MIN) : r;
    endfunction

    // Error counter stops at its top value
    function automatic perr_t sat_inc(perr_t e);
        return (e == {PERR_W{1'b1}}) ? e : e + perr_t'(1);
    endfunction

endpackage

// File: rtl/refpfd_rdiv.sv
module refpfd_rdiv
    import refpfd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rval_t r_val,
    output logic  tc,
    output rval_t r_cur
);

    rval_t cnt_q;
    rval_t ratio_q;

    assign tc    = (cnt_q == ratio_q - rval_t'(1));
    assign r_cur = ratio_q;

    // The ratio is reloaded only at terminal count: no shortened period
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ratio_q <= clamp_ratio(r_val);
        end else if (tc) begin
            cnt_q   <= '0;
            ratio_q <= clamp_ratio(r_val);
        end else begin
            cnt_q   <= cnt_q + rval_t'(1);
        end
    end

endmodule

// File: rtl/refpfd_halve.sv
module refpfd_halve (
    input  logic clk,
    input  logic rst,
    input  logic tc,
    output logic ref_pulse
);

    logic phase_q;
    logic pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            if (tc) begin
                phase_q <= ~phase_q;
            end
            pulse_q <= tc & phase_q;
        end
    end

    assign ref_pulse = pulse_q;

endmodule

// File: rtl/refpfd_pfd.sv
module refpfd_pfd
    import refpfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_evt,
    input  logic        vco_evt,
    output pfd_flags_t  flags,
    output cmp_result_t result
);

    pfd_flags_t  flags_q;
    perr_t       span_q;
    cmp_result_t res_q;

    logic  want_up;
    logic  want_dn;
    logic  finish;
    logic  active;
    perr_t err_now;

    always_comb begin
        active  = flags_q.up | flags_q.dn;
        want_up = ref_evt | flags_q.up;
        want_dn = vco_evt | flags_q.dn;
        finish  = want_up & want_dn;
        err_now = active ? sat_inc(span_q) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            span_q  <= '0;
            res_q   <= '0;
        end else begin
            res_q.valid <= finish;
            res_q.err   <= err_now;
            if (finish) begin
                // Both flip-flops would be set: clear them together
                flags_q <= '0;
                span_q  <= '0;
            end else begin
                flags_q.up <= want_up;
                flags_q.dn <= want_dn;
                span_q     <= active ? sat_inc(span_q) : '0;
            end
        end
    end

    assign flags  = flags_q;
    assign result = res_q;

endmodule

// File: rtl/refpfd_lockwin.sv
module refpfd_lockwin
    import refpfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pfd_flags_t  flags,
    input  cmp_result_t result,
    input  perr_t       win,
    output logic        drive,
    output logic        level,
    output logic        locked
);

    logic locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= 1'b0;
        end else if (result.valid) begin
            locked_q <= (result.err <= win);
        end
    end

    always_comb begin
        drive  = (flags.up | flags.dn) & ~locked_q;
        level  = flags.up;
        locked = locked_q;
    end

endmodule

// File: rtl/refdiv_pfd.sv
module refdiv_pfd
    import refpfd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [REF_R_W-1:0]  r_val,
    input  logic [PERR_W-1:0]   win_cycles,
    input  logic                vco_pulse,
    output logic                ref_out,
    output logic                pd_drive,
    output logic                pd_level,
    output logic                lock_pull
);

    logic        r_tc;
    rval_t       r_cur;
    logic        ref_q;
    pfd_flags_t  flags;
    cmp_result_t result;
    logic        up_act;
    logic        dn_act;
    logic        cmp_valid;

    refpfd_rdiv i_rdiv (
        .clk   (clk),
        .rst   (rst),
        .r_val (r_val),
        .tc    (r_tc),
        .r_cur (r_cur)
    );

    refpfd_halve i_halve (
        .clk       (clk),
        .rst       (rst),
        .tc        (r_tc),
        .ref_pulse (ref_q)
    );

    refpfd_pfd i_pfd (
        .clk     (clk),
        .rst     (rst),
        .ref_evt (ref_q),
        .vco_evt (vco_pulse),
        .flags   (flags),
        .result  (result)
    );

    refpfd_lockwin i_lock (
        .clk    (clk),
        .rst    (rst),
        .flags  (flags),
        .result (result),
        .win    (win_cycles),
        .drive  (pd_drive),
        .level  (pd_level),
        .locked (lock_pull)
    );

    assign ref_out   = ref_q;
    assign up_act    = flags.up;
    assign dn_act    = flags.dn;
    assign cmp_valid = result.valid;

endmodule

// File: rtl/refdiv_pfd_chk.sv
module refdiv_pfd_chk
    import refpfd_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  ref_out,
    input logic  pd_drive,
    input logic  pd_level,
    input logic  lock_pull,
    input logic  up_act,
    input logic  dn_act,
    input logic  cmp_valid,
    input rval_t r_cur
);

    AST_REF_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        ref_out |=> !ref_out);                                   // R1

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        r_cur >= rval_t'(R_MIN));                                // R2

    AST_DRIVE_NEEDS_STATE: assert property (@(posedge clk) disable iff (rst)
        pd_drive |-> (up_act || dn_act));                        // R4

    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (pd_drive && $past(pd_drive)) |-> $stable(pd_level));    // R5

    AST_UP_DN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(up_act && dn_act));                                    // R6

    AST_LOCK_AFTER_COMPARE: assert property (@(posedge clk) disable iff (rst)
        (lock_pull != $past(lock_pull)) |-> $past(cmp_valid));   // R7

    AST_RELEASED_WHEN_LOCKED: assert property (@(posedge clk) disable iff (rst)
        lock_pull |-> !pd_drive);                                // R8

endmodule

bind refdiv_pfd refdiv_pfd_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .ref_out   (ref_out),
    .pd_drive  (pd_drive),
    .pd_level  (pd_level),
    .lock_pull (lock_pull),
    .up_act    (up_act),
    .dn_act    (dn_act),
    .cmp_valid (cmp_valid),
    .r_cur     (r_cur)
);

// File: tb/test_refdiv_pfd.sv
module test_refdiv_pfd;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] r_val = 11'd10;
    logic [11:0] win_cycles = 12'd3;
    logic        vco_pulse = 1'b0;
    logic        ref_out;
    logic        pd_drive;
    logic        pd_level;
    logic        lock_pull;

    refdiv_pfd i_refdiv_pfd (
        .clk        (clk),
        .rst        (rst),
        .r_val      (r_val),
        .win_cycles (win_cycles),
        .vco_pulse  (vco_pulse),
        .ref_out    (ref_out),
        .pd_drive   (pd_drive),
        .pd_level   (pd_level),
        .lock_pull  (lock_pull)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  prev_lock = 1'b0;
    int  t_last = 0;
    bit  t_valid = 1'b0;
    int  rcur = 10;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 180000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            report();
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int eff_ratio(int r);
        return (r < 3) ? 3 : r;
    endfunction

    function automatic int absv(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(ref_out == 1'b0, "R9 ref_out in reset", int'(ref_out), 0);
        check(pd_drive == 1'b0, "R9 pd_drive in reset", int'(pd_drive), 0);
        check(lock_pull == 1'b0, "R9 lock_pull in reset", int'(lock_pull), 0);
        rst = 1'b0;
        prev_lock = 1'b0;
        t_valid = 1'b0;
    endtask

    task automatic wait_ref();
        do @(negedge clk); while (!ref_out);
    endtask

    // Reference pulse at t, VCO pulse d cycles later
    task automatic lag(int d, int w);
        int t;
        bit exp_lock;
        win_cycles = 12'(w);
        wait_ref();
        t = cyc;
        if (t_valid) check(t == t_last + 2 * rcur, "R1 spacing", t - t_last, 2 * rcur);
        if (d == 0) vco_pulse = 1'b1;
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            check(pd_drive == !prev_lock, prev_lock ? "R8 released" : "R4 up drive",
                  int'(pd_drive), int'(!prev_lock));
            if (!prev_lock) check(pd_level == 1'b1, "R4 up level", int'(pd_level), 1);
            if (k == d) vco_pulse = 1'b1;
        end
        @(negedge clk);
        vco_pulse = 1'b0;
        check(pd_drive == 1'b0, (d == 0) ? "R6 coincident no drive" : "R4 drive ends",
              int'(pd_drive), 0);
        @(negedge clk);
        check(pd_drive == 1'b0, "R6 idle", int'(pd_drive), 0);
        @(negedge clk);
        exp_lock = (d <= w);
        check(lock_pull == exp_lock, "R7 lock decision", int'(lock_pull), int'(exp_lock));
        prev_lock = exp_lock;
        t_last = t;
        t_valid = 1'b1;
    endtask

    // VCO pulse d cycles ahead of the next reference pulse
    task automatic lead(int d, int w);
        int tn;
        bit exp_lock;
        win_cycles = 12'(w);
        tn = t_last + 2 * rcur;
        while (cyc < tn - d) @(negedge clk);
        vco_pulse = 1'b1;
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            if (k == 1) vco_pulse = 1'b0;
            check(pd_drive == !prev_lock, prev_lock ? "R8 released" : "R5 down drive",
                  int'(pd_drive), int'(!prev_lock));
            if (!prev_lock) check(pd_level == 1'b0, "R5 down level", int'(pd_level), 0);
        end
        check(ref_out == 1'b1, "R1 reference on time", int'(ref_out), 1);
        @(negedge clk);
        check(pd_drive == 1'b0, "R5 drive ends", int'(pd_drive), 0);
        @(negedge clk);
        @(negedge clk);
        exp_lock = (d <= w);
        check(lock_pull == exp_lock, "R7 lock decision", int'(lock_pull), int'(exp_lock));
        prev_lock = exp_lock;
        t_last = tn;
    endtask

    task automatic measure_period(int exp, string tag);
        int t0;
        wait_ref();
        t0 = cyc;
        @(negedge clk);
        check(ref_out == 1'b0, "R1 one-cycle pulse", int'(ref_out), 0);
        wait_ref();
        check(cyc - t0 == exp, tag, cyc - t0, exp);
    endtask

    task automatic set_ratio(int r, string tag);
        r_val = 11'(r);
        wait_ref();
        wait_ref();
        measure_period(2 * eff_ratio(r), tag);
    endtask

    task automatic ratio_change(int o, int n, int delay);
        int t0;
        int iv;
        set_ratio(o, "R1 period before change");
        wait_ref();
        repeat (delay) @(negedge clk);
        r_val = 11'(n);
        t0 = cyc - delay;
        for (int i = 0; i < 3; i++) begin
            wait_ref();
            iv = cyc - t0;
            check(iv == 2 * o || iv == o + n || iv == 2 * n, "R3 no truncated interval", iv, o + n);
            t0 = cyc;
        end
        check(iv == 2 * n, "R3 settled interval", iv, 2 * n);
    endtask

    initial begin
        int d;
        int w;
        int r;
        void'($urandom(32'd4242));
        rcur = 10;
        r_val = 11'd10;
        do_reset();

        // Directed lead/lag corner cases, window 3
        lag(7, 3);
        lag(2, 3);
        lag(5, 3);
        lead(4, 3);
        lead(3, 3);
        lead(2, 3);
        lag(3, 3);
        lag(4, 3);
        lag(0, 3);
        lag(0, 0);
        lag(1, 0);
        lead(1, 0);

        // Random offsets and windows
        for (int i = 0; i < 16; i++) begin
            d = int'($urandom_range(0, 12)) - 6;
            w = int'($urandom_range(0, 5));
            if (d > 0 && ($urandom_range(0, 1) == 1)) lead(d, w);
            else lag(absv(d), w);
        end

        lag(1, 3);
        check(lock_pull == 1'b1, "R7 locked before reset", int'(lock_pull), 1);
        do_reset();
        @(negedge clk);
        check(lock_pull == 1'b0, "R9 unlocked after reset", int'(lock_pull), 0);

        // Divider ratios, VCO idle
        set_ratio(3, "R2 minimum ratio");
        set_ratio(1, "R2 clamp of 1");
        set_ratio(0, "R2 clamp of 0");
        set_ratio(2, "R2 clamp of 2");
        set_ratio(2047, "R2 maximum ratio");
        for (int i = 0; i < 4; i++) begin
            r = int'($urandom_range(3, 200));
            set_ratio(r, "R1 random ratio");
        end
        ratio_change(5, 9, 0);
        ratio_change(9, 4, 4);
        ratio_change(6, 20, 7);

        report();
    end

endmodule